// File: doc/BRIEF.md
# Retriggerable Clock Brake Timer

This block tells a clock-switching stage when a processor has to leave its fast clock and run from a slow reference clock. It watches a set of active-low trigger lines, for example an I/O request strobe. While any of them is low, it holds the active-low brake request `brake_n` low. When the last trigger has gone high again, it keeps the request low for a programmable number of counting-clock cycles and then releases it.

The trigger lines pass through a two-stage synchronizer into the counting clock domain. While a synchronized trigger is active, the counter is held at zero. Counting starts only once every trigger is inactive. A trigger that arrives during the count clears the counter again.

When the count reaches the selected terminal value, `brake_n` goes high and the counter freezes. The block then stays in this released state until the next trigger. The terminal value is picked from power-of-two taps, and the select input is only taken in while the brake request is low.

Top module: `brake_timer`

## Requirements
- R1: When any trigger line is held low across a rising clock edge, `brake_n` is low after the third rising edge from that sample. This latency comes from two synchronizer stages plus the output register.
- R2: `brake_n` stays low for as long as any trigger line remains low.
- R3: Let the last trigger line be released at a falling edge. `brake_n` then first reads high after rising edge number term+2 counted from that release.
- R4: A trigger that arrives while the count is running clears the counter. The full term then restarts from the later release.
- R5: The term is 2^(sel+1) cycles, where `tap_sel` = sel is in 0..7. This gives a range of 2 to 256 cycles.
- R6: Once `brake_n` is high, it stays high for as long as all trigger lines stay high.
- R7: While `rst` is high, `brake_n` is low. After `rst` is released with no trigger active, `brake_n` first reads high after rising edge number term. Even at the longest tap, this is at most 256 edges.
- R8: Changes on `tap_sel` while `brake_n` is high have no effect on `brake_n`. The select is captured only while `brake_n` is low.
- R9: The trigger lines are combined by OR of their active levels. Each line on its own produces the full brake behaviour. With overlapping triggers, the count starts from the last release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock (normally the slow reference) |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | N_TRIG | Active-low trigger lines, asynchronous to clk |
| tap_sel | input | SEL_W | Terminal tap select, term = 2^(tap_sel+1) |
| brake_n | output | 1 | Registered active-low brake request |

## Verification
The hard case to reach is a retrigger that lands partway through a running count. From the outside, that state looks the same as a count that simply started earlier. The stimulus releases a trigger and waits about half a term, checking that `brake_n` is still low. It then pulses a trigger again and measures the exact edge at which `brake_n` rises after the second release, which must be a full term+2 later.

A second ordering overlaps two triggers and releases them far apart. This exposes any design that starts counting on the first release instead of the last. Every tap is swept for every trigger line, so each tap value and each OR input is covered.

// File: rtl/brk_pkg.sv
package brk_pkg;
  // Smallest terminal exponent: tap 0 gives 2^(0+1) cycles
  localparam int unsigned TAP_BASE = 1;

  typedef enum logic {
    BRK_ACTIVE   = 1'b0,
    BRK_RELEASED = 1'b1
  } brk_level_e;
endpackage

// File: rtl/brk_trig_sync.sv
module brk_trig_sync #(
  parameter int unsigned N_TRIG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_n,
  output logic              any_act
);
  logic [N_TRIG-1:0] meta_q;
  logic [N_TRIG-1:0] sync_q;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= ~trig_n[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign any_act = |sync_q;
endmodule

// File: rtl/brk_tap_hold.sv
module brk_tap_hold #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [SEL_W-1:0] tap_sel,
  output logic [SEL_W-1:0] held_sel,
  output logic [CNT_W-1:0] last_idx
);
  import brk_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || load_en) held_sel <= tap_sel;
  end

  // last index = 2^(sel+1) - 1, a mask of the low (sel+1) bits
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      last_idx[i] = (i < (int'(held_sel) + int'(TAP_BASE)));
    end
  end
endmodule

// File: rtl/brk_count_core.sv
module brk_count_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_act,
  input  logic [CNT_W-1:0] last_idx,
  output logic [CNT_W-1:0] cnt,
  output logic             brake_n
);
  import brk_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || any_act) begin
      cnt     <= '0;
      brake_n <= BRK_ACTIVE;
    end else if (brake_n == BRK_ACTIVE) begin
      if (cnt >= last_idx) brake_n <= BRK_RELEASED;
      else                 cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/brake_timer.sv
module brake_timer #(
  parameter int unsigned N_TRIG = 4,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_n,
  input  logic [SEL_W-1:0]  tap_sel,
  output logic              brake_n
);
  logic             any_act;
  logic [SEL_W-1:0] held_sel_w;
  logic [CNT_W-1:0] last_idx_w;
  logic [CNT_W-1:0] cnt_w;

  brk_trig_sync #(.N_TRIG(N_TRIG)) u_sync (
    .clk(clk), .rst(rst), .trig_n(trig_n), .any_act(any_act)
  );

  brk_tap_hold #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_tap (
    .clk(clk), .rst(rst), .load_en(~brake_n), .tap_sel(tap_sel),
    .held_sel(held_sel_w), .last_idx(last_idx_w)
  );

  brk_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .any_act(any_act), .last_idx(last_idx_w),
    .cnt(cnt_w), .brake_n(brake_n)
  );
endmodule

// File: rtl/brake_timer_chk.sv
module brake_timer_chk #(
  parameter int unsigned N_TRIG = 4,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_TRIG-1:0] trig_n,
  input logic              brake_n,
  input logic [SEL_W-1:0]  held_sel,
  input logic [CNT_W-1:0]  cnt
);
  // R1
  trig_to_brake_chk: assert property (@(posedge clk) disable iff (rst)
    !(&trig_n) |-> ##3 !brake_n);

  // R3
  rise_after_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(brake_n) |-> ($past(&trig_n, 1) && $past(&trig_n, 2) && $past(&trig_n, 3)));

  // R6
  released_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (brake_n && (&trig_n) && $past(&trig_n) && $past(&trig_n, 2)) |=> brake_n);

  // R8
  sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(brake_n) |-> $stable(held_sel));

  // R6
  cnt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (brake_n && $past(brake_n)) |-> $stable(cnt));
endmodule

bind brake_timer brake_timer_chk #(.N_TRIG(N_TRIG), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .trig_n(trig_n), .brake_n(brake_n),
  .held_sel(held_sel_w), .cnt(cnt_w)
);

// File: tb/sim_brake_timer.sv
module sim_brake_timer;
  localparam int N_TRIG = 3;
  localparam int SEL_W  = 3;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N_TRIG-1:0] trig_n = '1;
  logic [SEL_W-1:0]  tap_sel = '0;
  logic              brake_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  brake_timer #(.N_TRIG(N_TRIG), .SEL_W(SEL_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .trig_n(trig_n), .tap_sel(tap_sel), .brake_n(brake_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count rising edges after the current falling edge until brake_n reads high
  task automatic measure(output int k);
    k = 0;
    do begin
      @(posedge clk); k++;
      @(negedge clk);
    end while (!brake_n && k < 600);
  endtask

  initial begin
    int k;
    int term;
    int bad;

    // R7: reset state and release with shortest tap
    step(4);
    chk(brake_n == 1'b0, "R7 reset level", brake_n, 0);
    rst = 1'b0;
    measure(k);
    chk(k == 2, "R7 release tap0", k, 2);

    // R7: longest tap from reset
    rst = 1'b1; tap_sel = 3'd7;
    step(3);
    rst = 1'b0;
    measure(k);
    chk(k == 256, "R7 release tap7", k, 256);

    // R1 R2 R3 R5 R6 R9: every tap for every line
    for (int s = 0; s < 8; s++) begin
      for (int t = 0; t < N_TRIG; t++) begin
        term = 1 << (s + 1);
        tap_sel = SEL_W'(s);
        trig_n[t] = 1'b0;
        step(3);
        chk(brake_n == 1'b0, "R1 R9 trigger latency", brake_n, 0);
        bad = 0;
        for (int i = 0; i < 6; i++) begin step(1); if (brake_n) bad++; end
        chk(bad == 0, "R2 held trigger", bad, 0);
        trig_n[t] = 1'b1;
        measure(k);
        chk(k == term + 2, "R3 R5 release to rise", k, term + 2);
        bad = 0;
        for (int i = 0; i < 20; i++) begin step(1); if (!brake_n) bad++; end
        chk(bad == 0, "R6 stays released", bad, 0);
      end
    end

    // R4: retrigger in mid count (term 16)
    tap_sel = 3'd3;
    trig_n[0] = 1'b0; step(4);
    trig_n[0] = 1'b1; step(10);
    chk(brake_n == 1'b0, "R4 mid count low", brake_n, 0);
    trig_n[2] = 1'b0; step(2);
    trig_n[2] = 1'b1;
    measure(k);
    chk(k == 18, "R4 restart after retrigger", k, 18);

    // R9 R2: overlap, count from last release
    tap_sel = 3'd2;
    trig_n[0] = 1'b0; trig_n[1] = 1'b0; step(4);
    trig_n[0] = 1'b1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin step(1); if (brake_n) bad++; end
    chk(bad == 0, "R9 overlap held", bad, 0);
    trig_n[1] = 1'b1;
    measure(k);
    chk(k == 10, "R9 overlap last release", k, 10);

    // R8: select changes while released have no effect on the output
    bad = 0;
    for (int s = 0; s < 8; s++) begin
      tap_sel = SEL_W'(s);
      for (int i = 0; i < 5; i++) begin step(1); if (!brake_n) bad++; end
    end
    chk(bad == 0, "R8 select ignored while released", bad, 0);
    tap_sel = 3'd0;
    trig_n[1] = 1'b0; step(3);
    trig_n[1] = 1'b1;
    measure(k);
    chk(k == 4, "R8 select taken while braking", k, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule